// File: doc/BRIEF.md
# Word Transfer Handshake Controller

This block runs the flag-driven word handshakes between a processor and external input and output units. It keeps three flags. The device-ready flag is set by the external device and cleared by the processor. The input-request flag asks the input unit for a word. The output-request flag tells the output unit that a word is waiting on the output lines. A free-running minor phase counter splits time into execute periods of `PHASES` cycles. The last phase of each period is the only point where a command can start and the only point where completion is tested.

A read command clears the device-ready flag and raises the input request. The controller then tests the device-ready flag once per period. When the flag is set, it writes the input lines into the accumulator load port, drops the request and pulses `done`. A write command clears the device-ready flag, drives the accumulator value onto the output lines and raises the output request. When the device-ready flag is found set, it drops the request and pulses `done`. The control sequencer uses `minorPhase` to line up its own major cycles and uses `done` to leave the execute state.

Top module: `io_handshake`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `minorPhase`, `reqIn`, `reqOut`, `dataFlag`, `dolOut`, `accWe` and `done` are all zero.
- R2: `minorPhase` counts 0, 1, … `PHASES-1` (3 by default) and then wraps to 0, without stopping. Phase `PHASES-1` is the start and test phase.
- R3: When the block is idle, `minorPhase` is `PHASES-1` and `cmdStart`=1 with `cmdWrite`=0, a read starts. In the next cycle `reqIn`=1 and `dataFlag`=0. `reqIn` and `reqOut` are never both 1.
- R4: The same start condition with `cmdWrite`=1 starts a write. In the next cycle `reqOut`=1, `dataFlag`=0 and `dolOut` equals the `accIn` value sampled at the start.
- R5: `cmdStart` has no effect in any other phase, or while a command is in progress.
- R6: A `devDataSet` pulse sets `dataFlag` in the next cycle, except in a start cycle. The flag stays set until a later command starts.
- R7: Completion is tested only in phase `PHASES-1` of an execute period. If `dataFlag` is 0 there, the block waits a full further period before it tests again.
- R8: On read completion, `done`=1 and `accWe`=1 in the same cycle, with `accWdata` equal to `dilIn`. In the next cycle `reqIn`=0.
- R9: On write completion, `done`=1 and `accWe`=0. In the next cycle `reqOut`=0. `dolOut` does not change while `reqOut` is 1.
- R10: A `devDataSet` that arrives before a command starts is discarded at the start. The command then needs a new device set before it can complete.
- R11: `done` lasts exactly one cycle for each completed command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Command request from the sequencer |
| cmdWrite | input | 1 | 1 = write (output), 0 = read (input) |
| accIn | input | WIDTH | Accumulator value to send on a write |
| dilIn | input | WIDTH | Data input lines from the input unit |
| devDataSet | input | 1 | Device pulse that sets the device-ready flag |
| minorPhase | output | PW | Current minor phase |
| reqIn | output | 1 | Input-request flag |
| reqOut | output | 1 | Output-request flag |
| dataFlag | output | 1 | Device-ready flag |
| dolOut | output | WIDTH | Data output lines |
| accWe | output | 1 | Accumulator load strobe |
| accWdata | output | WIDTH | Accumulator load value |
| done | output | 1 | One-cycle completion pulse |

## Verification
A phase counter that slips shows up at `minorPhase` in the next cycle. It also moves every later start and completion away from the cycles the bench predicts. A command state that stays busy or returns to idle too early appears at `reqIn`/`reqOut` in the cycle after the wrong edge. It also shows as a missing or extra `done` at the next test phase, at most `PHASES` cycles later. A device-ready flag that is not cleared at a start gives a `done` one period early. The bench compares every output against a cycle model in every cycle, so each of these faults is caught within one execute period.

// File: rtl/io_hs_pkg.sv
package io_hs_pkg;

  typedef struct packed {
    logic startRd;
    logic startWr;
    logic finishRd;
    logic finishWr;
  } hsStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } hsState_t;

endpackage

// File: rtl/io_hs_ctrl.sv
module io_hs_ctrl
  import io_hs_pkg::*;
#(
  parameter int PHASES = 4,
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmdStart,
  input  logic          cmdWrite,
  input  logic          dataFlag,
  output logic [PW-1:0] phase,
  output hsStrobe_t     strb,
  output logic          done
);

  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  hsState_t state;
  logic     opWrite;
  logic     atLast;
  logic     accept;
  logic     hit;

  assign atLast = (phase == LAST);
  assign accept = (state == ST_IDLE) && atLast && cmdStart;
  assign hit    = (state == ST_EXEC) && atLast && dataFlag;

  always_comb begin
    strb.startRd  = accept && !cmdWrite;
    strb.startWr  = accept && cmdWrite;
    strb.finishRd = hit && !opWrite;
    strb.finishWr = hit && opWrite;
  end

  assign done = strb.finishRd || strb.finishWr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (atLast) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      opWrite <= 1'b0;
    end else if (accept) begin
      state   <= ST_EXEC;
      opWrite <= cmdWrite;
    end else if (hit) begin
      state <= ST_IDLE;
    end
  end

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == LAST) |=> (phase == '0));

  // R7
  done_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == LAST));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/io_hs_path.sv
module io_hs_path
  import io_hs_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hsStrobe_t        strb,
  input  logic             devDataSet,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] dilIn,
  output logic             dataFlag,
  output logic             reqIn,
  output logic             reqOut,
  output logic [WIDTH-1:0] dolOut,
  output logic             accWe,
  output logic [WIDTH-1:0] accWdata
);

  logic anyStart;
  assign anyStart = strb.startRd || strb.startWr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dataFlag <= 1'b0;
    end else if (anyStart) begin
      dataFlag <= 1'b0;
    end else if (devDataSet) begin
      dataFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqIn <= 1'b0;
    end else if (strb.startRd) begin
      reqIn <= 1'b1;
    end else if (strb.finishRd) begin
      reqIn <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqOut <= 1'b0;
      dolOut <= '0;
    end else if (strb.startWr) begin
      reqOut <= 1'b1;
      dolOut <= accIn;
    end else if (strb.finishWr) begin
      reqOut <= 1'b0;
    end
  end

  assign accWe    = strb.finishRd;
  assign accWdata = dilIn;

  // R3
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reqIn, reqOut}));

  // R9
  dol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reqOut && $past(reqOut)) |-> $stable(dolOut));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anyStart |=> !dataFlag);

endmodule

// File: rtl/io_handshake.sv
module io_handshake
  import io_hs_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int PHASES = 4,
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdStart,
  input  logic             cmdWrite,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] dilIn,
  input  logic             devDataSet,
  output logic [PW-1:0]    minorPhase,
  output logic             reqIn,
  output logic             reqOut,
  output logic             dataFlag,
  output logic [WIDTH-1:0] dolOut,
  output logic             accWe,
  output logic [WIDTH-1:0] accWdata,
  output logic             done
);

  hsStrobe_t strb;

  io_hs_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdStart (cmdStart),
    .cmdWrite (cmdWrite),
    .dataFlag (dataFlag),
    .phase    (minorPhase),
    .strb     (strb),
    .done     (done)
  );

  io_hs_path #(.WIDTH(WIDTH)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .devDataSet (devDataSet),
    .accIn      (accIn),
    .dilIn      (dilIn),
    .dataFlag   (dataFlag),
    .reqIn      (reqIn),
    .reqOut     (reqOut),
    .dolOut     (dolOut),
    .accWe      (accWe),
    .accWdata   (accWdata)
  );

endmodule

// File: tb/io_handshake_bench.sv
module io_handshake_bench;

  localparam int WIDTH  = 16;
  localparam int PHASES = 4;
  localparam int PW     = 2;
  localparam int LASTP  = PHASES - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmdStart = 1'b0;
  logic             cmdWrite = 1'b0;
  logic [WIDTH-1:0] accIn = '0;
  logic [WIDTH-1:0] dilIn = '0;
  logic             devDataSet = 1'b0;
  logic [PW-1:0]    minorPhase;
  logic             reqIn, reqOut, dataFlag, accWe, done;
  logic [WIDTH-1:0] dolOut, accWdata;

  io_handshake #(.WIDTH(WIDTH), .PHASES(PHASES)) u_io_handshake (
    .clk(clk), .rst_n(rst_n), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .accIn(accIn), .dilIn(dilIn), .devDataSet(devDataSet),
    .minorPhase(minorPhase), .reqIn(reqIn), .reqOut(reqOut),
    .dataFlag(dataFlag), .dolOut(dolOut), .accWe(accWe),
    .accWdata(accWdata), .done(done)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  int          mPhase;
  bit          mBusy, mWr, mData, mIn, mOut;
  logic [WIDTH-1:0] mDol;
  bit          prevStart, prevDone, prevReject;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit expDone();
    return mBusy && (mPhase == LASTP) && mData;
  endfunction

  function automatic bit expAccept(input bit c);
    return !mBusy && (mPhase == LASTP) && c;
  endfunction

  task automatic modelReset();
    mPhase = 0; mBusy = 0; mWr = 0; mData = 0; mIn = 0; mOut = 0;
    mDol = '0; prevStart = 0; prevDone = 0; prevReject = 0;
  endtask

  // one cycle: drive at negedge, check, advance model after posedge
  task automatic step(input bit c, input bit w, input bit d);
    bit acc, fin;
    cmdStart = c; cmdWrite = w; devDataSet = d;
    accIn = WIDTH'($urandom); dilIn = WIDTH'($urandom);
    #1;
    chk("R2", "minorPhase", 32'(minorPhase), 32'(mPhase));
    chk(prevReject ? "R5" : "R3", "reqIn", 32'(reqIn), 32'(mIn));
    chk(prevReject ? "R5" : "R4", "reqOut", 32'(reqOut), 32'(mOut));
    chk("R9", "dolOut", 32'(dolOut), 32'(mDol));
    chk(prevStart ? "R10" : "R6", "dataFlag", 32'(dataFlag), 32'(mData));
    chk(prevDone ? "R11" : "R7", "done", 32'(done), 32'(expDone()));
    chk("R8", "accWe", 32'(accWe), 32'(expDone() && !mWr));
    if (expDone() && !mWr) chk("R8", "accWdata", 32'(accWdata), 32'(dilIn));
    acc = expAccept(c);
    fin = expDone();
    @(posedge clk);
    prevStart  = acc;
    prevDone   = fin;
    prevReject = c && !acc;
    if (acc) begin
      mData = 0; mBusy = 1; mWr = w; mIn = !w; mOut = w;
      if (w) mDol = accIn;
    end else begin
      if (fin) begin mIn = 0; mOut = 0; mBusy = 0; end
      if (d) mData = 1;
    end
    mPhase = (mPhase == LASTP) ? 0 : mPhase + 1;
    @(negedge clk);
  endtask

  task automatic randSeg(input int cycles, input int pCmd, input int pDev);
    for (int i = 0; i < cycles; i++)
      step(($urandom % 100) < pCmd, $urandom % 2,
           ($urandom % 100) < pDev);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    // R1: values while reset is held
    chk("R1", "minorPhase", 32'(minorPhase), 0);
    chk("R1", "reqIn", 32'(reqIn), 0);
    chk("R1", "reqOut", 32'(reqOut), 0);
    chk("R1", "dataFlag", 32'(dataFlag), 0);
    chk("R1", "dolOut", 32'(dolOut), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "accWe", 32'(accWe), 0);
    rst_n = 1'b1;

    // R10: device set while idle, then a read start must discard it
    while (mPhase != LASTP - 1) step(0, 0, 0);
    step(0, 0, 1);          // flag set in idle
    step(1, 0, 0);          // read starts in the last phase
    for (int i = 0; i < PHASES; i++) step(0, 0, 0);  // no completion expected
    chk("R10", "reqIn still high", 32'(reqIn), 1);
    step(0, 0, 1);
    while (mBusy) step(0, 0, 0);

    // R5: command offered in every non-last phase, then during busy
    while (mPhase != 0) step(0, 0, 0);
    for (int i = 0; i < LASTP; i++) step(1, 1, 0);
    step(1, 1, 0);          // write accepted
    for (int i = 0; i < 2 * PHASES; i++) step(1, 0, 0);
    chk("R5", "reqIn stays low", 32'(reqIn), 0);
    step(0, 0, 1);
    while (mBusy) step(0, 0, 0);

    // R7: device set exactly in the test phase counts one period later
    while (!(mPhase == LASTP && !mBusy)) step(0, 0, 0);
    step(1, 0, 0);
    while (mPhase != LASTP) step(0, 0, 0);
    step(0, 0, 1);
    for (int i = 0; i < PHASES; i++) step(0, 0, 0);

    // random mixes
    randSeg(800, 50, 30);
    randSeg(800, 90, 5);
    randSeg(800, 20, 90);
    randSeg(800, 100, 100);
    randSeg(800, 70, 50);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog run did not end actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule